// File: doc/BRIEF.md
# Three-Channel Compare/Capture Timer

This block is a timer peripheral with three channels, each built around a 16-bit up-counter. A counter advances by one on every clock while its channel's run bit is set, and holds while the bit is clear. Each channel owns general registers. Channel 0 has four, slots A, B, C and D. Channels 1 and 2 have two each, slots A and B. A per-register control field sets each general register to act as a compare register or as a capture register. In compare mode the register drives an output pin. In capture mode it samples the counter when its input pin shows a chosen edge.

On channel 0, slot C can act as a shadow for slot A and slot D as a shadow for slot B. In compare mode, a match reloads the primary register from its shadow. In capture mode, a capture first moves the old primary value into the shadow.

All registers sit on a simple word-addressed bus with a combinational read path. The bus has a width flag: high means a full 16-bit access, low means a byte access.

Top module: `cc_timer3`

Register map (word addresses on `bus_addr`):

| Address | Contents |
|---|---|
| 0x00 | Run register. Bit n runs channel n. |
| 0x01 | Shadow enables. Bit 0 pairs A with C, bit 1 pairs B with D. |
| 0x04–0x06 | Counters of channels 0–2. |
| 0x08–0x0F | General-register slots 0–7, in the order ch0 A, B, C, D, ch1 A, B, ch2 A, B. |
| 0x10–0x17 | Control fields of slots 0–7. |

Each control field has four bits:

| Bits | Meaning |
|---|---|
| [3] | 1 selects capture mode. |
| [2] | Initial pin level. |
| [1:0] | In compare mode: 0 no change, 1 drive low, 2 drive high, 3 toggle. In capture mode: 0 rising edge, 1 falling edge, 2 or 3 either edge. |

Slot s drives `cmp_out[s]` and samples `cap_in[s]`.

## Requirements
- R1: After reset every counter reads 0x0000, every general register reads 0xFFFF, the run register reads 0, and every `cmp_out` bit is 0.
- R2: A counter whose run bit is 1 increases by one on each clock and wraps from 0xFFFF to 0x0000. A counter whose run bit is 0 holds its value.
- R3: The run register at address 0x00 stores bits 2:0. Bits 7:3 and every bit above them read as 0, whatever was written to them.
- R4: For counters (0x04–0x06) and general registers (0x08–0x0F), a byte access (`bus_wide`=0) is ignored on write and reads back 0.
- R5: In compare mode, when the channel is running and its counter equals the register, `cmp_out` takes the programmed action at that clock edge. The action codes are 0 no change, 1 low, 2 high, 3 toggle.
- R6: While a channel's run bit is 0, its `cmp_out` bits keep their level unless their control field is written.
- R7: Writing a control field while the channel's run bit is 0 drives the slot's `cmp_out` to bit 2 of the written value at that edge. The same write while running leaves the pin unchanged.
- R8: In capture mode, the edge chosen by bits 1:0 (0 rising, 1 falling, 2 or 3 both) on `cap_in` loads the counter value into the register. The load happens at the third clock edge after the input changes, because the input passes through two synchronizer flops.
- R9: With shadow enable bit 0 (or bit 1) set, a compare match on channel 0 slot A (or B) loads slot C (or D) into that slot. With the enable bit clear, the slot is left unchanged.
- R10: With a shadow enable set and slot A (or B) in capture mode, a capture moves the old slot A (or B) value into slot C (or D) while the counter value enters slot A (or B).
- R11: A full-width bus write to a running counter takes precedence over that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_wide | input | 1 | 1 full 16-bit access, 0 byte access |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| cap_in | input | 8 | Capture input, one per slot |
| cmp_out | output | 8 | Compare output, one per slot |

## Verification
A counter that steps wrongly or misses its run bit shows up in the next counter read-back, and in a compare pin that changes one cycle early or late. A wrong synchronizer depth or a wrong edge decode leaves a captured value that does not match the counter value held while stopped, and this is visible three edges after the input moves. A fault in the shadow pairing appears at the first match or capture, because the primary or shadow slot reads back a value that the bench can predict exactly.

// File: rtl/cct_pkg.sv
// Shared constants and types of the compare/capture timer.
// Assumes a fixed layout of three channels and eight register slots.
package cct_pkg;
    localparam int NCH      = 3;
    localparam int NSLOT    = 8;
    localparam int A_RUN    = 0;
    localparam int A_SHADOW = 1;
    localparam int A_CNT    = 4;
    localparam int A_GR     = 8;
    localparam int A_IOC    = 16;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } cmp_act_e;

    typedef struct packed {
        logic       cap_mode;
        logic       init_lvl;
        logic [1:0] sel;
    } ioc_t;

    // Channel that owns a register slot.
    function automatic int slot_chan(input int s);
        return (s < 4) ? 0 : ((s < 6) ? 1 : 2);
    endfunction
endpackage

// File: rtl/cct_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and flags edges.
// Assumes STAGES >= 2; rise/fall are one-cycle pulses.
module cct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cct_counter.sv
// Free-running up-counter of one channel; a bus write beats the increment.
// Assumes wr_en is already qualified as a full-width write.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt
);
    // Load, step or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_en) cnt <= wr_val;
        else if (run)   cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/cct_gr_slot.sv
// One general register with its control field, compare pin and capture input.
// Assumes the parent handles shadow pairing through alt_load/alt_val;
// priority is bus write, then capture, then shadow transfer.
module cct_gr_slot
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         run,
    input  logic         active,
    input  logic         pin_in,
    input  logic         gr_wr,
    input  logic         ioc_wr,
    input  logic [W-1:0] wdata,
    input  logic         alt_load,
    input  logic [W-1:0] alt_val,
    output logic [W-1:0] gr,
    output logic [3:0]   ioc,
    output logic         pin,
    output logic         cmp_hit,
    output logic         cap_hit
);
    ioc_t ioc_q;
    logic rise, fall, edge_ok;

    cct_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(rise), .fall(fall)
    );

    // Decode which synchronized edge the control field selects.
    always_comb begin
        unique case (ioc_q.sel)
            2'd0:    edge_ok = rise;
            2'd1:    edge_ok = fall;
            default: edge_ok = rise | fall;
        endcase
    end

    assign cap_hit = active & ioc_q.cap_mode & edge_ok;
    assign cmp_hit = active & ~ioc_q.cap_mode & run & (cnt == gr);
    assign ioc     = ioc_q;

    // Update the register value.
    always_ff @(posedge clk) begin
        if (!rst_n)        gr <= '1;
        else if (gr_wr)    gr <= wdata;
        else if (cap_hit)  gr <= cnt;
        else if (alt_load) gr <= alt_val;
    end

    // Hold the control field.
    always_ff @(posedge clk) begin
        if (!rst_n)      ioc_q <= '0;
        else if (ioc_wr) ioc_q <= ioc_t'(wdata[3:0]);
    end

    // Drive the compare pin: forced level when stopped, else action on match.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else if (ioc_wr && !run) pin <= wdata[2];
        else if (cmp_hit) begin
            unique case (cmp_act_e'(ioc_q.sel))
                ACT_NONE:   pin <= pin;
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                ACT_TOGGLE: pin <= ~pin;
            endcase
        end
    end
endmodule

// File: rtl/cc_timer3.sv
// Three-channel compare/capture timer with a word-addressed register bus.
// Assumes a single clock; cap_in is asynchronous and synchronized per slot.
module cc_timer3
    import cct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NSLOT-1:0]  cap_in,
    output logic [NSLOT-1:0]  cmp_out
);
    logic             wr_any, wr_full;
    logic [NCH-1:0]   start_q;
    logic [1:0]       shadow_q;
    logic [CNT_W-1:0] cnt_q   [NCH];
    logic [CNT_W-1:0] gr_q    [NSLOT];
    logic [CNT_W-1:0] alt_val [NSLOT];
    logic [3:0]       ioc_v   [NSLOT];
    logic [NSLOT-1:0] cmp_hit, cap_hit, alt_load, active;

    assign wr_any  = bus_sel & bus_wr;
    assign wr_full = wr_any & bus_wide;

    // Run bits and shadow enables accept any access width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            shadow_q <= '0;
        end else if (wr_any && bus_addr == ADDR_W'(A_RUN)) begin
            start_q <= bus_wdata[NCH-1:0];
        end else if (wr_any && bus_addr == ADDR_W'(A_SHADOW)) begin
            shadow_q <= bus_wdata[1:0];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_cnt
        cct_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .run(start_q[c]),
            .wr_en(wr_full && bus_addr == ADDR_W'(A_CNT + c)),
            .wr_val(bus_wdata), .cnt(cnt_q[c])
        );
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int CH = slot_chan(s);
        if (s == 0 || s == 1) begin : g_primary
            assign active[s]   = 1'b1;
            assign alt_load[s] = shadow_q[s] & cmp_hit[s];
            assign alt_val[s]  = gr_q[s+2];
        end else if (s == 2 || s == 3) begin : g_shadow
            assign active[s]   = ~shadow_q[s-2];
            assign alt_load[s] = shadow_q[s-2] & cap_hit[s-2];
            assign alt_val[s]  = gr_q[s-2];
        end else begin : g_plain
            assign active[s]   = 1'b1;
            assign alt_load[s] = 1'b0;
            assign alt_val[s]  = '0;
        end

        cct_gr_slot #(.W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_q[CH]), .run(start_q[CH]),
            .active(active[s]), .pin_in(cap_in[s]),
            .gr_wr(wr_full && bus_addr == ADDR_W'(A_GR + s)),
            .ioc_wr(wr_any && bus_addr == ADDR_W'(A_IOC + s)),
            .wdata(bus_wdata), .alt_load(alt_load[s]), .alt_val(alt_val[s]),
            .gr(gr_q[s]), .ioc(ioc_v[s]), .pin(cmp_out[s]),
            .cmp_hit(cmp_hit[s]), .cap_hit(cap_hit[s])
        );
    end

    // Read mux; byte reads of counters and general registers return 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_RUN))    bus_rdata = CNT_W'(start_q);
        if (bus_addr == ADDR_W'(A_SHADOW)) bus_rdata = CNT_W'(shadow_q);
        for (int c = 0; c < NCH; c++) begin
            if (bus_wide && bus_addr == ADDR_W'(A_CNT + c)) bus_rdata = cnt_q[c];
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (bus_wide && bus_addr == ADDR_W'(A_GR + s))  bus_rdata = gr_q[s];
            if (bus_addr == ADDR_W'(A_IOC + s))             bus_rdata = CNT_W'(ioc_v[s]);
        end
    end
endmodule

// File: rtl/cc_timer3_chk.sv
// Property checker for cc_timer3, attached by bind below.
// Observes bus, pins, the run bits and the channel 0 counter.
module cc_timer3_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5,
    parameter int NCH    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic [7:0]        cmp_out,
    input logic [NCH-1:0]    start_q,
    input logic [CNT_W-1:0]  cnt0
);
    logic rd, cnt0_wr, ioc4_wr;
    assign rd      = bus_sel & ~bus_wr;
    assign cnt0_wr = bus_sel & bus_wr & bus_wide & (bus_addr == ADDR_W'(4));
    assign ioc4_wr = bus_sel & bus_wr & (bus_addr == ADDR_W'(20));

    AST_RUN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr == ADDR_W'(0) |-> bus_rdata[CNT_W-1:NCH] == '0); // R3
    AST_BYTE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !bus_wide && bus_addr >= ADDR_W'(4) && bus_addr < ADDR_W'(16) |-> bus_rdata == '0); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        start_q[0] && !cnt0_wr |=> cnt0 == CNT_W'($past(cnt0) + CNT_W'(1))); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q[0] && !cnt0_wr |=> $stable(cnt0)); // R2
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt0_wr |=> cnt0 == $past(bus_wdata)); // R11
    AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q[1] && !ioc4_wr |=> $stable(cmp_out[4])); // R6
endmodule

bind cc_timer3 cc_timer3_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NCH(3)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_out(cmp_out), .start_q(start_q), .cnt0(cnt_q[0])
);

// File: tb/cc_timer3_tb.sv
// Self-checking bench for cc_timer3: sweeps run lengths, compare actions,
// capture edge modes and the shadow pairs with arithmetic expectations.
module cc_timer3_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  cap_in = '0;
    logic [7:0]  cmp_out;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    cc_timer3 u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic w);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wide = 1'b1;
    endtask

    task automatic rd(input logic [4:0] a, input logic w, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_wide = w; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_wide = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1: reset values
        rd(5'h00, 1'b1, v); chk("R1 run", v, 16'h0000);
        for (int c = 0; c < 3; c++) begin
            rd(5'(4 + c), 1'b1, v); chk("R1 counter", v, 16'h0000);
        end
        for (int s = 0; s < 8; s++) begin
            rd(5'(8 + s), 1'b1, v); chk("R1 gr", v, 16'hFFFF);
        end
        chk("R1 pins", {8'h0, cmp_out}, 16'h0000);

        // R3: run register upper bits
        wr(5'h00, 16'h00F8, 1'b1);
        rd(5'h00, 1'b1, v); chk("R3 upper ignored", v, 16'h0000);
        wr(5'h00, 16'h0000, 1'b0);

        // R4: byte accesses to counters and general registers
        wr(5'h04, 16'h1234, 1'b0);
        rd(5'h04, 1'b1, v); chk("R4 byte write cnt", v, 16'h0000);
        wr(5'h09, 16'h5555, 1'b0);
        rd(5'h09, 1'b1, v); chk("R4 byte write gr", v, 16'hFFFF);
        rd(5'h09, 1'b0, v); chk("R4 byte read gr", v, 16'h0000);

        // R2: run-length sweep on channel 2 across the wrap point
        for (int m = 0; m < 8; m++) begin
            wr(5'h06, 16'hFFFC, 1'b1);
            wr(5'h00, 16'h0004, 1'b1);
            idle(m);
            wr(5'h00, 16'h0000, 1'b1);
            rd(5'h06, 1'b1, v); chk("R2 step/wrap", v, 16'(16'hFFFC + m + 1));
            idle(2);
            rd(5'h06, 1'b1, v); chk("R2 hold", v, 16'(16'hFFFC + m + 1));
        end

        // R11: bus write beats increment
        wr(5'h04, 16'h0000, 1'b1);
        wr(5'h00, 16'h0001, 1'b1);
        wr(5'h04, 16'h0100, 1'b1);
        wr(5'h00, 16'h0000, 1'b1);
        rd(5'h04, 1'b1, v); chk("R11 write wins", v, 16'h0101);

        // R5/R6/R7: compare action sweep on channel 1 slot A
        for (int init = 0; init < 2; init++) begin
            for (int act = 0; act < 4; act++) begin
                logic expv;
                wr(5'h14, 16'(init * 4 + act), 1'b1);
                chk("R7 forced level", {15'h0, cmp_out[4]}, 16'(init));
                wr(5'h0C, 16'h0005, 1'b1);
                wr(5'h05, 16'h0000, 1'b1);
                wr(5'h00, 16'h0002, 1'b1);
                idle(8);
                wr(5'h00, 16'h0000, 1'b1);
                case (act)
                    0: expv = 1'(init);
                    1: expv = 1'b0;
                    2: expv = 1'b1;
                    default: expv = ~1'(init);
                endcase
                chk("R5 compare action", {15'h0, cmp_out[4]}, {15'h0, expv});
                idle(3);
                chk("R6 frozen when stopped", {15'h0, cmp_out[4]}, {15'h0, expv});
            end
        end
        // R7: control write while running leaves the pin alone (pin is 0 here)
        wr(5'h0C, 16'hFFFF, 1'b1);
        wr(5'h00, 16'h0002, 1'b1);
        wr(5'h14, 16'h0004, 1'b1);
        chk("R7 running write", {15'h0, cmp_out[4]}, 16'h0000);
        wr(5'h00, 16'h0000, 1'b1);

        // R8: capture edge-mode sweep on channel 2 slot A (counter stopped)
        for (int e = 0; e < 3; e++) begin
            for (int d = 0; d < 2; d++) begin
                logic hit;
                cap_in[6] = ~1'(d);
                idle(4);
                wr(5'h16, 16'(8 + e), 1'b1);
                wr(5'h0E, 16'hFFFF, 1'b1);
                wr(5'h06, 16'(16'h0100 + e * 16 + d), 1'b1);
                cap_in[6] = 1'(d);
                idle(4);
                hit = (e == 0 && d == 1) || (e == 1 && d == 0) || (e == 2);
                rd(5'h0E, 1'b1, v);
                chk("R8 edge select", v, hit ? 16'(16'h0100 + e * 16 + d) : 16'hFFFF);
            end
        end
        // R8: latency of the synchronizer
        cap_in[6] = 1'b0;
        idle(4);
        wr(5'h16, 16'h0008, 1'b1);
        wr(5'h0E, 16'hFFFF, 1'b1);
        wr(5'h06, 16'h0ABC, 1'b1);
        cap_in[6] = 1'b1;
        idle(2);
        rd(5'h0E, 1'b1, v); chk("R8 not before third edge", v, 16'hFFFF);
        idle(1);
        rd(5'h0E, 1'b1, v); chk("R8 at third edge", v, 16'h0ABC);

        // R9: shadow on compare for A/C, none for B/D
        wr(5'h01, 16'h0001, 1'b1);
        wr(5'h10, 16'h0003, 1'b1);
        wr(5'h11, 16'h0000, 1'b1);
        wr(5'h08, 16'h0003, 1'b1);
        wr(5'h0A, 16'h0007, 1'b1);
        wr(5'h09, 16'h0003, 1'b1);
        wr(5'h0B, 16'h0009, 1'b1);
        wr(5'h04, 16'h0000, 1'b1);
        wr(5'h00, 16'h0001, 1'b1);
        idle(4);
        wr(5'h00, 16'h0000, 1'b1);
        rd(5'h08, 1'b1, v); chk("R9 A reloaded from C", v, 16'h0007);
        rd(5'h09, 1'b1, v); chk("R9 B unpaired unchanged", v, 16'h0003);
        chk("R9 pin toggled once", {15'h0, cmp_out[0]}, 16'h0001);

        // R10: shadow on capture for B/D
        wr(5'h01, 16'h0002, 1'b1);
        wr(5'h11, 16'h0008, 1'b1);
        wr(5'h09, 16'h1111, 1'b1);
        wr(5'h0B, 16'h2222, 1'b1);
        wr(5'h04, 16'h0042, 1'b1);
        cap_in[1] = 1'b1;
        idle(4);
        rd(5'h09, 1'b1, v); chk("R10 B captured", v, 16'h0042);
        rd(5'h0B, 1'b1, v); chk("R10 D got old B", v, 16'h1111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule